// File: doc/BRIEF.md
# PLL Lock and Source Switch Sequencer

This block decides, cycle by cycle, whether each system clock group and the USB clock take the external oscillator or a PLL output. It stands in front of the clock multiplexers and the PLL enables. Software reaches it through register-write strobes: one control word for each of the two PLLs (system and USB), a shared lock-time value, a slow-clock bit that powers the USB PLL down or up, and a source-select word with one bit per clock group. A programmable countdown takes the place of real PLL settling.

Out of reset every clock runs from the oscillator, even though both PLLs are already enabled. A PLL output is only adopted after a control-word write with the enable bit set, followed by a full lock countdown. A write of the unchanged default word also counts. While the USB PLL settles after such a write, the USB clock is held low instead of passing the oscillator through. When the USB PLL is powered back up, the USB clock stays on the oscillator while it settles. The USB output also encodes a 1:1 or 1:2 division of the PLL output.

Top module: `pll_src_seq`

## Requirements
- R1: After reset, grp_sel_o is all zero, usb_sel_o is 0 (oscillator), both locked flags are 0, pll_en_o is 2'b11, and sys_cfg_o and usb_cfg_o hold the fields of the reset control words.
- R2: A system control-word write with bit 31 set starts a countdown from the lock-time value held before that edge (L). The locked flag, and any PLL selection that depends on it, appears on the (L+1)th rising edge after the write edge. Until then, and after reset, every group is on the oscillator. This holds even when the written word equals the reset default.
- R3: In a control word, bit 31 is the enable, bits [25:16] are M, bits [13:8] are P and bits [2:0] are S. The cfg output is {M,P,S}, and it is updated on the write edge. All other bits have no effect.
- R4: The lock-time register is 16 bits wide and resets to 16'hFFFF. A new value is used by the next countdown that starts, and a value of 0 gives the locked flag one edge after the write.
- R5: For group g of the three groups, grp_sel_o[g] is 1 (PLL) only when source-select bit g is 1 and the system PLL is locked. Otherwise the group gets the oscillator (0). The source word resets to 3'b111, and a write made outside a countdown takes effect on its write edge.
- R6: Source-select writes made during a system countdown are held back. The last one is applied on the edge where the locked flag sets.
- R7: A control-word write during a countdown restarts that countdown from the lock-time value and returns the channel's outputs to their pre-lock state.
- R8: A control-word write with bit 31 clear drops that channel's pll_en_o bit (bit 0 system, bit 1 USB), clears its locked flag, cancels its countdown and routes its clocks to the oscillator.
- R9: A USB control-word write with bit 31 set, made while the USB PLL is powered, gives usb_sel_o = 1 (held low) for the whole countdown. After that the output is the PLL.
- R10: Writing the slow-clock bit to 1 powers the USB PLL down: pll_en_o[1] becomes 0, usb_sel_o becomes 0 and the USB locked flag clears, all on the write edge.
- R11: Writing the slow-clock bit to 0 after a USB control-word write powers the PLL up. usb_sel_o stays 0 through a full countdown and then selects the PLL. If no USB control word was ever written, usb_sel_o stays 0.
- R12: While the USB PLL is locked, usb_sel_o is 2 when usb_half_i is 0 (1:1) and 3 when usb_half_i is 1 (1:2). It follows usb_half_i within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sys_ctl_we_i | input | 1 | Write strobe, system PLL control word |
| sys_ctl_i | input | 32 | System PLL control word |
| usb_ctl_we_i | input | 1 | Write strobe, USB PLL control word |
| usb_ctl_i | input | 32 | USB PLL control word |
| lock_we_i | input | 1 | Write strobe, lock-time register |
| lock_i | input | LOCK_W | Lock-time value in cycles |
| slow_we_i | input | 1 | Write strobe, slow-clock bit |
| usb_off_i | input | 1 | Slow-clock bit: 1 powers the USB PLL down |
| src_we_i | input | 1 | Write strobe, source-select word |
| src_i | input | N_GRP | Source-select word, one bit per group |
| usb_half_i | input | 1 | USB divide: 0 gives 1:1, 1 gives 1:2 |
| grp_sel_o | output | N_GRP | Per-group mux select, 1 = PLL |
| usb_sel_o | output | 2 | USB mux: 0 osc, 1 low, 2 PLL, 3 PLL/2 |
| pll_en_o | output | 2 | PLL enables: bit 0 system, bit 1 USB |
| sys_locked_o | output | 1 | System PLL locked flag |
| usb_locked_o | output | 1 | USB PLL locked flag |
| sys_cfg_o | output | 19 | System {M,P,S} |
| usb_cfg_o | output | 19 | USB {M,P,S} |

## Verification
Register writes are taken on a rising edge, and every registered result appears on that same edge: the cfg fields, enable drops, power-down, source changes made outside a countdown, and the start of the hold-low state. The locked flag and the PLL selections follow on the (L+1)th edge after the start of a countdown. The divide bit acts within the cycle. The bench drives inputs on falling edges and samples half a cycle after the capture edge. It counts the falling edges between stimulus and check, and checks both sides of each countdown end: after L edges the flag must still be clear, and after L+1 it must be set. That includes the 65536-cycle reset default.

// File: rtl/pls_pkg.sv
package pls_pkg;
  localparam int CTL_W = 32;
  localparam int EN_BIT = 31;
  localparam int M_LSB = 16;
  localparam int M_W = 10;
  localparam int P_LSB = 8;
  localparam int P_W = 6;
  localparam int S_LSB = 0;
  localparam int S_W = 3;
  localparam int CFG_W = M_W + P_W + S_W;

  localparam logic [CTL_W-1:0] USED_MASK =
      (CTL_W'(1) << EN_BIT) |
      (((CTL_W'(1) << M_W) - 1) << M_LSB) |
      (((CTL_W'(1) << P_W) - 1) << P_LSB) |
      (((CTL_W'(1) << S_W) - 1) << S_LSB);

  typedef enum logic [1:0] {
    USB_OSC      = 2'd0,
    USB_LOW      = 2'd1,
    USB_PLL      = 2'd2,
    USB_PLL_HALF = 2'd3
  } usb_sel_e;
endpackage

// File: rtl/pll_lock_ctr.sv
module pll_lock_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [CNT_W-1:0] load_i,
  output logic             busy_o,
  output logic             locked_o,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic             locked_q;

  // start beats stop beats counting
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      busy_q   <= 1'b0;
      locked_q <= 1'b0;
    end else if (start_i) begin
      cnt_q    <= load_i;
      busy_q   <= 1'b1;
      locked_q <= 1'b0;
    end else if (stop_i) begin
      cnt_q    <= '0;
      busy_q   <= 1'b0;
      locked_q <= 1'b0;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_q   <= 1'b0;
        locked_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign busy_o   = busy_q;
  assign locked_o = locked_q;
  assign done_o   = busy_q && (cnt_q == '0) && !start_i && !stop_i;

  assert_lock_from_count_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_q) |-> $past(busy_q));
  assert_restart_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (busy_q && !locked_q));
  assert_cancel_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !start_i) |=> (!busy_q && !locked_q));
  assert_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_q && locked_q));
endmodule

// File: rtl/pll_chan.sv
module pll_chan
  import pls_pkg::*;
#(
  parameter int              CNT_W    = 16,
  parameter logic [CTL_W-1:0] RST_WORD = 32'h805C_0301
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctl_we_i,
  input  logic [CTL_W-1:0] ctl_i,
  input  logic             off_we_i,
  input  logic             off_i,
  input  logic [CNT_W-1:0] lock_val_i,
  output logic             pll_en_o,
  output logic [CFG_W-1:0] cfg_o,
  output logic             busy_o,
  output logic             locked_o,
  output logic             hold_o,
  output logic             done_o
);
  localparam logic [CFG_W-1:0] RST_CFG =
      {RST_WORD[M_LSB+:M_W], RST_WORD[P_LSB+:P_W], RST_WORD[S_LSB+:S_W]};

  logic             en_q, off_q, cfgd_q, hold_q;
  logic [CFG_W-1:0] cfg_q;
  logic             en_n, off_n, run_n, run_q;
  logic             start, stop, done;
  logic             unused_bits;

  assign unused_bits = ^(ctl_i & ~USED_MASK);

  assign en_n  = ctl_we_i ? ctl_i[EN_BIT] : en_q;
  assign off_n = off_we_i ? off_i : off_q;
  assign run_n = en_n && !off_n;
  assign run_q = en_q && !off_q;
  // fresh config, or power-up of an already configured PLL
  assign start = run_n && (ctl_we_i || (!run_q && cfgd_q));
  assign stop  = !run_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= RST_WORD[EN_BIT];
      cfg_q  <= RST_CFG;
      off_q  <= 1'b0;
      cfgd_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      if (ctl_we_i) begin
        en_q   <= ctl_i[EN_BIT];
        cfg_q  <= {ctl_i[M_LSB+:M_W], ctl_i[P_LSB+:P_W], ctl_i[S_LSB+:S_W]};
        cfgd_q <= 1'b1;
      end
      if (off_we_i) off_q <= off_i;
      if (start)     hold_q <= ctl_we_i;
      else if (done) hold_q <= 1'b0;
    end
  end

  pll_lock_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .stop_i   (stop),
    .load_i   (lock_val_i),
    .busy_o   (busy_o),
    .locked_o (locked_o),
    .done_o   (done)
  );

  assign pll_en_o = run_q;
  assign cfg_o    = cfg_q;
  assign hold_o   = hold_q;
  assign done_o   = done;

  assert_cfg_take_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_we_i |=> (cfg_o[S_W-1:0] == $past(ctl_i[S_LSB+:S_W])));
  assert_en_drop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_we_i && !ctl_i[EN_BIT]) |=> (!pll_en_o && !locked_o));
  assert_unconf_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfgd_q |-> !busy_o);
endmodule

// File: rtl/src_defer.sv
module src_defer #(
  parameter int N_GRP = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [N_GRP-1:0] src_i,
  input  logic             busy_i,
  input  logic             done_i,
  input  logic             locked_i,
  output logic [N_GRP-1:0] sel_o
);
  logic [N_GRP-1:0] act_q, pend_q;
  logic             pend_v_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q    <= '1;
      pend_q   <= '0;
      pend_v_q <= 1'b0;
    end else if (done_i) begin
      if (we_i)          act_q <= src_i;
      else if (pend_v_q) act_q <= pend_q;
      pend_v_q <= 1'b0;
    end else if (we_i && busy_i) begin
      pend_q   <= src_i;
      pend_v_q <= 1'b1;
    end else if (we_i) begin
      act_q <= src_i;
    end
  end

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    assign sel_o[g] = act_q[g] && locked_i;
  end

  assert_defer_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && busy_i && !done_i) |=> $stable(act_q));
  assert_idle_take_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !busy_i) |=> (act_q == $past(src_i)));
endmodule

// File: rtl/pll_src_seq.sv
module pll_src_seq
  import pls_pkg::*;
#(
  parameter int               N_GRP        = 3,
  parameter int               LOCK_W       = 16,
  parameter logic [CTL_W-1:0] SYS_RST_WORD = 32'h805C_0301,
  parameter logic [CTL_W-1:0] USB_RST_WORD = 32'h8038_0202
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sys_ctl_we_i,
  input  logic [31:0]       sys_ctl_i,
  input  logic              usb_ctl_we_i,
  input  logic [31:0]       usb_ctl_i,
  input  logic              lock_we_i,
  input  logic [LOCK_W-1:0] lock_i,
  input  logic              slow_we_i,
  input  logic              usb_off_i,
  input  logic              src_we_i,
  input  logic [N_GRP-1:0]  src_i,
  input  logic              usb_half_i,
  output logic [N_GRP-1:0]  grp_sel_o,
  output logic [1:0]        usb_sel_o,
  output logic [1:0]        pll_en_o,
  output logic              sys_locked_o,
  output logic              usb_locked_o,
  output logic [18:0]       sys_cfg_o,
  output logic [18:0]       usb_cfg_o
);
  localparam int N_CH = 2;
  localparam int SYS = 0;
  localparam int USB = 1;

  logic [LOCK_W-1:0]          lock_q;
  logic [N_CH-1:0]            ch_we, ch_off_we, ch_off;
  logic [N_CH-1:0][CTL_W-1:0] ch_word;
  logic [N_CH-1:0][CFG_W-1:0] ch_cfg;
  logic [N_CH-1:0]            ch_en, ch_busy, ch_locked, ch_hold, ch_done;
  usb_sel_e                   usb_sel;
  logic                       unused_ch;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        lock_q <= '1;
    else if (lock_we_i) lock_q <= lock_i;
  end

  assign ch_we     = {usb_ctl_we_i, sys_ctl_we_i};
  assign ch_word   = {usb_ctl_i, sys_ctl_i};
  assign ch_off_we = {slow_we_i, 1'b0};
  assign ch_off    = {usb_off_i, 1'b0};

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    localparam logic [CTL_W-1:0] RW = (c == SYS) ? SYS_RST_WORD : USB_RST_WORD;
    pll_chan #(.CNT_W(LOCK_W), .RST_WORD(RW)) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ctl_we_i   (ch_we[c]),
      .ctl_i      (ch_word[c]),
      .off_we_i   (ch_off_we[c]),
      .off_i      (ch_off[c]),
      .lock_val_i (lock_q),
      .pll_en_o   (ch_en[c]),
      .cfg_o      (ch_cfg[c]),
      .busy_o     (ch_busy[c]),
      .locked_o   (ch_locked[c]),
      .hold_o     (ch_hold[c]),
      .done_o     (ch_done[c])
    );
  end

  src_defer #(.N_GRP(N_GRP)) u_src (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (src_we_i),
    .src_i    (src_i),
    .busy_i   (ch_busy[SYS]),
    .done_i   (ch_done[SYS]),
    .locked_i (ch_locked[SYS]),
    .sel_o    (grp_sel_o)
  );

  always_comb begin
    if (ch_locked[USB])                     usb_sel = usb_half_i ? USB_PLL_HALF : USB_PLL;
    else if (ch_busy[USB] && ch_hold[USB])  usb_sel = USB_LOW;
    else                                    usb_sel = USB_OSC;
  end

  assign unused_ch    = ch_hold[SYS] ^ ch_done[USB];
  assign usb_sel_o    = usb_sel;
  assign pll_en_o     = ch_en;
  assign sys_locked_o = ch_locked[SYS];
  assign usb_locked_o = ch_locked[USB];
  assign sys_cfg_o    = ch_cfg[SYS];
  assign usb_cfg_o    = ch_cfg[USB];

  assert_usb_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (usb_ctl_we_i && usb_ctl_i[EN_BIT] && pll_en_o[USB] && !(slow_we_i && usb_off_i))
      |=> (usb_sel_o == USB_LOW));
  assert_usb_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slow_we_i && usb_off_i) |=> (usb_sel_o == USB_OSC && !pll_en_o[USB] && !usb_locked_o));
  assert_sys_relock_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_ctl_we_i |=> (grp_sel_o == '0));
endmodule

// File: tb/pll_src_seq_tb.sv
module pll_src_seq_tb;
  typedef enum logic [2:0] {OP_NOP, OP_SCTL, OP_UCTL, OP_LOCK, OP_SRC, OP_OFF, OP_ON} op_e;
  typedef struct packed {
    op_e         op;
    logic [31:0] dat;
    logic [7:0]  wt;
    logic [3:0]  req;
    logic [2:0]  grp;
    logic [1:0]  usb;
    logic        slk;
    logic        ulk;
    logic [1:0]  pll;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{OP_OFF,  32'h0,         8'd0, 4'd10, 3'b000, 2'd0, 1'b0, 1'b0, 2'b01}, // R10
    '{OP_ON,   32'h0,         8'd3, 4'd11, 3'b000, 2'd0, 1'b0, 1'b0, 2'b11}, // R11 never configured
    '{OP_LOCK, 32'd3,         8'd0, 4'd4,  3'b000, 2'd0, 1'b0, 1'b0, 2'b11}, // R4
    '{OP_SCTL, 32'h805C_0301, 8'd3, 4'd2,  3'b000, 2'd0, 1'b0, 1'b0, 2'b11}, // R2 default word, L edges
    '{OP_NOP,  32'h0,         8'd0, 4'd2,  3'b111, 2'd0, 1'b1, 1'b0, 2'b11}, // R2 L+1
    '{OP_SRC,  32'h5,         8'd0, 4'd5,  3'b101, 2'd0, 1'b1, 1'b0, 2'b11}, // R5
    '{OP_UCTL, 32'h8038_0202, 8'd0, 4'd9,  3'b101, 2'd1, 1'b1, 1'b0, 2'b11}, // R9
    '{OP_NOP,  32'h0,         8'd2, 4'd9,  3'b101, 2'd1, 1'b1, 1'b0, 2'b11}, // R9
    '{OP_NOP,  32'h0,         8'd0, 4'd12, 3'b101, 2'd2, 1'b1, 1'b1, 2'b11}, // R12 1:1
    '{OP_OFF,  32'h0,         8'd0, 4'd10, 3'b101, 2'd0, 1'b1, 1'b0, 2'b01}, // R10
    '{OP_ON,   32'h0,         8'd3, 4'd11, 3'b101, 2'd0, 1'b1, 1'b0, 2'b11}, // R11
    '{OP_NOP,  32'h0,         8'd0, 4'd11, 3'b101, 2'd2, 1'b1, 1'b1, 2'b11}, // R11
    '{OP_SCTL, 32'h805C_0301, 8'd1, 4'd7,  3'b000, 2'd2, 1'b0, 1'b1, 2'b11}, // R7
    '{OP_SRC,  32'h2,         8'd0, 4'd6,  3'b000, 2'd2, 1'b0, 1'b1, 2'b11}, // R6
    '{OP_SCTL, 32'h805C_0301, 8'd3, 4'd7,  3'b000, 2'd2, 1'b0, 1'b1, 2'b11}, // R7 restart
    '{OP_NOP,  32'h0,         8'd0, 4'd6,  3'b010, 2'd2, 1'b1, 1'b1, 2'b11}, // R6
    '{OP_SCTL, 32'h005C_0301, 8'd0, 4'd8,  3'b000, 2'd2, 1'b0, 1'b1, 2'b10}, // R8
    '{OP_SCTL, 32'h805C_0301, 8'd4, 4'd8,  3'b010, 2'd2, 1'b1, 1'b1, 2'b11}  // R8
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sys_we = 1'b0, usb_we = 1'b0, lock_we = 1'b0, slow_we = 1'b0, src_we = 1'b0;
  logic [31:0] sys_w = '0, usb_w = '0;
  logic [15:0] lock_w = '0;
  logic        usb_off = 1'b0, usb_half = 1'b0;
  logic [2:0]  src_w = '0;
  logic [2:0]  grp_sel;
  logic [1:0]  usb_sel, pll_en;
  logic        sys_lk, usb_lk;
  logic [18:0] sys_cfg, usb_cfg;
  int          checks = 0;
  int          errors = 0;

  always #5 clk = ~clk;

  pll_src_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .sys_ctl_we_i(sys_we), .sys_ctl_i(sys_w),
    .usb_ctl_we_i(usb_we), .usb_ctl_i(usb_w),
    .lock_we_i(lock_we), .lock_i(lock_w),
    .slow_we_i(slow_we), .usb_off_i(usb_off),
    .src_we_i(src_we), .src_i(src_w),
    .usb_half_i(usb_half),
    .grp_sel_o(grp_sel), .usb_sel_o(usb_sel), .pll_en_o(pll_en),
    .sys_locked_o(sys_lk), .usb_locked_o(usb_lk),
    .sys_cfg_o(sys_cfg), .usb_cfg_o(usb_cfg)
  );

  // called at a falling edge; captured on the next rising edge
  task automatic drive(input op_e op, input logic [31:0] d);
    case (op)
      OP_SCTL: begin sys_we = 1'b1; sys_w = d; end
      OP_UCTL: begin usb_we = 1'b1; usb_w = d; end
      OP_LOCK: begin lock_we = 1'b1; lock_w = d[15:0]; end
      OP_SRC:  begin src_we = 1'b1; src_w = d[2:0]; end
      OP_OFF:  begin slow_we = 1'b1; usb_off = 1'b1; end
      OP_ON:   begin slow_we = 1'b1; usb_off = 1'b0; end
      default: ;
    endcase
    @(negedge clk);
    sys_we = 1'b0; usb_we = 1'b0; lock_we = 1'b0; slow_we = 1'b0; src_we = 1'b0;
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] snap();
    return {55'd0, grp_sel, usb_sel, sys_lk, usb_lk, pll_en};
  endfunction

  task automatic chk_reset();
    chk("R1 outputs", snap(), {55'd0, 3'b000, 2'd0, 1'b0, 1'b0, 2'b11});
    chk("R1 cfg", {26'd0, sys_cfg, usb_cfg},
        {26'd0, 10'h05C, 6'h03, 3'h1, 10'h038, 6'h02, 3'h2});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_reset();
    rst_n = 1'b1;
    @(negedge clk);
    chk_reset();

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].op, VEC[i].dat);
      repeat (int'(VEC[i].wt)) @(negedge clk);
      checks++;
      if (snap() !== {55'd0, VEC[i].grp, VEC[i].usb, VEC[i].slk, VEC[i].ulk, VEC[i].pll}) begin
        errors++;
        $display("FAIL R%0d vec %0d actual grp=%b usb=%0d slk=%b ulk=%b en=%b expected grp=%b usb=%0d slk=%b ulk=%b en=%b",
                 VEC[i].req, i, grp_sel, usb_sel, sys_lk, usb_lk, pll_en,
                 VEC[i].grp, VEC[i].usb, VEC[i].slk, VEC[i].ulk, VEC[i].pll);
      end
    end

    // R12: divide bit acts within the cycle
    usb_half = 1'b1;
    @(negedge clk);
    chk("R12 half", {62'd0, usb_sel}, 64'd3);
    usb_half = 1'b0;

    // R3: field decode, stray bits ignored
    drive(OP_SCTL, 32'hFD23_EAFD);
    chk("R3 fields", {45'd0, sys_cfg}, {45'd0, 10'h123, 6'h2A, 3'h5});

    // R4: zero lock time
    drive(OP_LOCK, 32'd0);
    drive(OP_SCTL, 32'h805C_0301);
    chk("R4 zero lock pending", {63'd0, sys_lk}, 64'd0);
    @(negedge clk);
    chk("R4 zero lock done", {63'd0, sys_lk}, 64'd1);

    // R8: USB enable clear
    drive(OP_UCTL, 32'h0038_0202);
    chk("R8 usb disable", {60'd0, usb_sel, pll_en}, {60'd0, 2'd0, 2'b01});

    // R1 again, then R4 default lock time of 16'hFFFF
    rst_n = 1'b0;
    @(negedge clk);
    chk_reset();
    rst_n = 1'b1;
    @(negedge clk);
    drive(OP_SCTL, 32'h805C_0301);
    repeat (65535) @(negedge clk);
    chk("R4 default lock pending", {63'd0, sys_lk}, 64'd0);
    @(negedge clk);
    chk("R2 default lock done", {60'd0, grp_sel, sys_lk}, {60'd0, 3'b111, 1'b1});

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule